// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block decides, for one SIMD multiprocessor, which resident warp sends its next instruction to the execution units at each issue opportunity. Every warp holds a program counter and a small scoreboard of destination registers that are still in flight. A warp is eligible when its next instruction touches no pending register, its scoreboard has room, and the unit class the instruction needs is free. The main group of 8 scalar lanes runs one 32-thread warp instruction for four clocks. A multiply unit beside it, which also takes double-precision work, can accept one instruction from a different warp in the same slot.

The scheduler also manages residency. A warp is launched into the lowest free slot only if its register demand (per-thread count times 32) fits in the unallocated part of a 16384-entry register file. Retiring a warp frees its slot and its registers. Writeback completions clear scoreboard entries. Among eligible warps a round-robin pointer, one per unit, starts the search just after the last warp issued, so no ready warp starves.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is resident, and no issue occurs even when instruction descriptors are presented.
- R2: An issue on the main lanes blocks the next main issue for 4 clocks. For a 32-bit integer multiply (op code 2) the block lasts 16 clocks.
- R3: A warp does not issue while a source register or the destination register of its next instruction matches a pending scoreboard entry of that warp.
- R4: A completion pulse sampled at one clock edge clears the matching entry at the next edge. A waiting warp can issue in the cycle after that edge, and not before.
- R5: A warp whose 4 scoreboard entries are all pending does not issue.
- R6: Among eligible main-lane warps, the grant goes to the first one found at increasing index, wrapping, starting after the last main-issued warp. The pointer starts at the highest index.
- R7: In the slot where a main-lane instruction issues, at most one secondary instruction from another warp may also issue. Single-precision multiply and double-precision work share this one port, with a separate round-robin pointer.
- R8: A launch is accepted only if a slot is free and the per-thread register count times 32 is no more than the unallocated registers. The warp goes into the lowest-numbered free slot.
- R9: A retire frees the slot and the registers at the same edge. A launch in the same cycle as the retire is judged against the budget and slots as they were before the retire.
- R10: The reported program counter of a warp's first issue equals its launch value, and it rises by one for each later issue of that warp.
- R11: Op codes: 0 is a main-lane ALU or MAD, 1 is a secondary multiply, 2 is a 32-bit integer multiply on the main lanes, and 3 is double-precision work on the secondary port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_vld | input | NW | Per-warp next-instruction valid |
| ins_op | input | 2*NW | Per-warp op code, 2 bits per warp |
| ins_dst | input | RW*NW | Per-warp destination register |
| ins_sa | input | RW*NW | Per-warp first source register |
| ins_sb | input | RW*NW | Per-warp second source register |
| wb_vld | input | 1 | Writeback completion pulse |
| wb_wid | input | WIDW | Warp of the completion |
| wb_reg | input | RW | Register of the completion |
| launch_req | input | 1 | Request to admit a new warp |
| launch_regs | input | RPTW | Registers per thread of the new warp |
| launch_pc | input | PCW | Start program counter of the new warp |
| launch_ack | output | 1 | Launch accepted this cycle |
| launch_wid | output | WIDW | Slot given to the accepted warp |
| retire_vld | input | 1 | Retire request |
| retire_wid | input | WIDW | Slot to retire |
| main_vld | output | 1 | Issue to the main lanes |
| main_wid | output | WIDW | Warp issued to the main lanes |
| main_op | output | 2 | Op code of the main issue |
| main_pc | output | PCW | Program counter of the main issue |
| sec_vld | output | 1 | Issue to the secondary port |
| sec_wid | output | WIDW | Warp issued to the secondary port |
| sec_op | output | 2 | Op code of the secondary issue |
| sec_pc | output | PCW | Program counter of the secondary issue |

## Verification
A retire and a launch can land in the same cycle. The bench first fills the budget so that a further launch does not fit. It then raises retire and launch together and expects a refusal, because that cycle still sees the old budget. On the next cycle it expects the launch to be accepted into the slot just freed. A completion can also arrive while the main lanes sit idle with a blocked warp waiting. There, the issue must appear exactly one cycle after the completion is registered, no earlier and no later.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_MUL  = 2'd1,
        OP_IMUL = 2'd2,
        OP_DFP  = 2'd3
    } op_e;

    function automatic logic on_main_lanes(op_e op);
        return (op == OP_ALU) || (op == OP_IMUL);
    endfunction

    // clocks the main lane group stays occupied by one warp instruction
    function automatic int slot_clocks(op_e op, int warp, int lanes, int imul_mult);
        int base;
        base = warp / lanes;
        return (op == OP_IMUL) ? base * imul_mult : base;
    endfunction

endpackage

// File: rtl/warp_scoreboard.sv
module warp_scoreboard #(
    parameter int DEPTH = 4,
    parameter int RW    = 6,
    localparam int DW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_reg,
    input  logic [RW-1:0] chk_a,
    input  logic [RW-1:0] chk_b,
    input  logic [RW-1:0] chk_d,
    output logic          haz,
    output logic          full
);

    logic [DEPTH-1:0] v_q;
    logic [RW-1:0]    r_q [DEPTH];
    logic [DW-1:0]    fidx;

    always_comb begin
        fidx = '0;
        haz  = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!v_q[DW'(i)]) fidx = DW'(i);
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (v_q[DW'(i)] && (r_q[DW'(i)] == chk_a || r_q[DW'(i)] == chk_b ||
                                r_q[DW'(i)] == chk_d))
                haz = 1'b1;
        end
    end

    assign full = &v_q;

    // clears are applied first so that a set to the same entry wins
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            v_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr_en && v_q[DW'(i)] && r_q[DW'(i)] == clr_reg)
                    v_q[DW'(i)] <= 1'b0;
            end
            if (set_en) v_q[fidx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en && !flush) r_q[fidx] <= set_reg;
    end

    // R5
    sb_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !flush) |-> !full);

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        int c;
        any = 1'b0;
        idx = last;
        for (int k = 1; k <= N; k++) begin
            c = (int'(last) + k) % N;
            if (!any && req[IW'(c)]) begin
                any = 1'b1;
                idx = IW'(c);
            end
        end
    end

endmodule

// File: rtl/residency_ctrl.sv
module residency_ctrl #(
    parameter int NW      = 32,
    parameter int WARP    = 32,
    parameter int RF_REGS = 16384,
    parameter int RPTW    = 8,
    localparam int WIDW   = $clog2(NW),
    localparam int BUDW   = $clog2(RF_REGS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch_req,
    input  logic [RPTW-1:0] launch_regs,
    input  logic            retire_vld,
    input  logic [WIDW-1:0] retire_wid,
    output logic            launch_ack,
    output logic [WIDW-1:0] launch_wid,
    output logic [NW-1:0]   resident
);

    logic [BUDW-1:0] free_q;
    logic [BUDW-1:0] alloc_q [NW];
    logic            slot_ok;
    logic [WIDW-1:0] slot;
    logic            ret_ok;
    int              need_i;

    always_comb begin
        slot_ok = 1'b0;
        slot    = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (!resident[WIDW'(i)]) begin
                slot_ok = 1'b1;
                slot    = WIDW'(i);
            end
        end
    end

    assign need_i     = int'(launch_regs) * WARP;
    assign launch_ack = launch_req && slot_ok && (need_i <= int'(free_q));
    assign launch_wid = slot;
    assign ret_ok     = retire_vld && resident[retire_wid];

    always_ff @(posedge clk) begin
        if (rst) begin
            resident <= '0;
            free_q   <= BUDW'(RF_REGS);
        end else begin
            if (ret_ok)     resident[retire_wid] <= 1'b0;
            if (launch_ack) resident[slot]       <= 1'b1;
            free_q <= free_q - (launch_ack ? BUDW'(need_i) : '0)
                             + (ret_ok ? alloc_q[retire_wid] : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (launch_ack) alloc_q[slot] <= BUDW'(need_i);
    end

    // R8
    budget_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        int'(free_q) <= RF_REGS);

    // R8
    launch_fill_chk: assert property (@(posedge clk) disable iff (rst)
        launch_ack |=> resident[$past(slot)]);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_ok && !launch_ack) |=> (free_q >= $past(free_q)) && !resident[$past(retire_wid)]);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import sched_pkg::*;
#(
    parameter int MAX_THREADS = 1024,
    parameter int WARP        = 32,
    parameter int LANES       = 8,
    parameter int RF_REGS     = 16384,
    parameter int SB_DEPTH    = 4,
    parameter int IMUL_MULT   = 4,
    parameter int RW          = 6,
    parameter int PCW         = 16,
    parameter int RPTW        = 8,
    localparam int NW         = MAX_THREADS / WARP,
    localparam int WIDW       = $clog2(NW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NW-1:0]    ins_vld,
    input  logic [2*NW-1:0]  ins_op,
    input  logic [RW*NW-1:0] ins_dst,
    input  logic [RW*NW-1:0] ins_sa,
    input  logic [RW*NW-1:0] ins_sb,
    input  logic             wb_vld,
    input  logic [WIDW-1:0]  wb_wid,
    input  logic [RW-1:0]    wb_reg,
    input  logic             launch_req,
    input  logic [RPTW-1:0]  launch_regs,
    input  logic [PCW-1:0]   launch_pc,
    output logic             launch_ack,
    output logic [WIDW-1:0]  launch_wid,
    input  logic             retire_vld,
    input  logic [WIDW-1:0]  retire_wid,
    output logic             main_vld,
    output logic [WIDW-1:0]  main_wid,
    output logic [1:0]       main_op,
    output logic [PCW-1:0]   main_pc,
    output logic             sec_vld,
    output logic [WIDW-1:0]  sec_wid,
    output logic [1:0]       sec_op,
    output logic [PCW-1:0]   sec_pc
);

    localparam int BUSYW = $clog2(WARP / LANES * IMUL_MULT + 1);

    logic [NW-1:0]     resident, haz, full, el_main, el_sec, sb_set, sb_clr, flush;
    logic [PCW*NW-1:0] pc_flat;
    logic              wbq_vld;
    logic [WIDW-1:0]   wbq_wid;
    logic [RW-1:0]     wbq_reg;
    logic [BUSYW-1:0]  busy_q;
    logic              opp;
    logic [WIDW-1:0]   m_last, s_last, m_idx, s_idx;
    logic              m_any, s_any;

    residency_ctrl #(.NW(NW), .WARP(WARP), .RF_REGS(RF_REGS), .RPTW(RPTW)) u_res (
        .clk(clk), .rst(rst), .launch_req(launch_req), .launch_regs(launch_regs),
        .retire_vld(retire_vld), .retire_wid(retire_wid), .launch_ack(launch_ack),
        .launch_wid(launch_wid), .resident(resident)
    );

    for (genvar w = 0; w < NW; w++) begin : g_warp
        op_e            opw;
        logic [RW-1:0]  dw, aw, bw;
        logic           rdy;
        logic [PCW-1:0] pc_r;

        assign opw = op_e'(ins_op[2*w +: 2]);
        assign dw  = ins_dst[RW*w +: RW];
        assign aw  = ins_sa[RW*w +: RW];
        assign bw  = ins_sb[RW*w +: RW];
        assign rdy = resident[w] & ins_vld[w] & ~haz[w] & ~full[w];
        assign el_main[w] = rdy & on_main_lanes(opw);
        assign el_sec[w]  = rdy & ~on_main_lanes(opw);
        assign sb_set[w]  = (main_vld && main_wid == WIDW'(w)) ||
                            (sec_vld && sec_wid == WIDW'(w));
        assign sb_clr[w]  = wbq_vld && wbq_wid == WIDW'(w);
        assign flush[w]   = (launch_ack && launch_wid == WIDW'(w)) ||
                            (retire_vld && retire_wid == WIDW'(w));

        warp_scoreboard #(.DEPTH(SB_DEPTH), .RW(RW)) u_sb (
            .clk(clk), .rst(rst), .flush(flush[w]),
            .set_en(sb_set[w]), .set_reg(dw),
            .clr_en(sb_clr[w]), .clr_reg(wbq_reg),
            .chk_a(aw), .chk_b(bw), .chk_d(dw),
            .haz(haz[w]), .full(full[w])
        );

        always_ff @(posedge clk) begin
            if (rst)                                        pc_r <= '0;
            else if (launch_ack && launch_wid == WIDW'(w))  pc_r <= launch_pc;
            else if (sb_set[w])                             pc_r <= pc_r + 1'b1;
        end
        assign pc_flat[PCW*w +: PCW] = pc_r;
    end

    rr_picker #(.N(NW)) u_pick_main (.req(el_main), .last(m_last), .any(m_any), .idx(m_idx));
    rr_picker #(.N(NW)) u_pick_sec  (.req(el_sec),  .last(s_last), .any(s_any), .idx(s_idx));

    assign opp      = (busy_q == '0);
    assign main_vld = opp && m_any;
    assign main_wid = m_idx;
    assign main_op  = ins_op[{m_idx, 1'b0} +: 2];
    assign main_pc  = pc_flat[PCW*int'(m_idx) +: PCW];
    assign sec_vld  = opp && s_any;
    assign sec_wid  = s_idx;
    assign sec_op   = ins_op[{s_idx, 1'b0} +: 2];
    assign sec_pc   = pc_flat[PCW*int'(s_idx) +: PCW];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= '0;
            m_last  <= WIDW'(NW - 1);
            s_last  <= WIDW'(NW - 1);
            wbq_vld <= 1'b0;
            wbq_wid <= '0;
            wbq_reg <= '0;
        end else begin
            wbq_vld <= wb_vld;
            wbq_wid <= wb_wid;
            wbq_reg <= wb_reg;
            if (main_vld)
                busy_q <= BUSYW'(slot_clocks(op_e'(main_op), WARP, LANES, IMUL_MULT) - 1);
            else if (busy_q != '0)
                busy_q <= busy_q - 1'b1;
            if (main_vld) m_last <= m_idx;
            if (sec_vld)  s_last <= s_idx;
        end
    end

    // R2
    main_gap_chk: assert property (@(posedge clk) disable iff (rst)
        main_vld |=> !main_vld ##1 !main_vld ##1 !main_vld);

    // R3
    hazard_issue_chk: assert property (@(posedge clk) disable iff (rst)
        main_vld |-> !haz[main_wid] && resident[main_wid]);

    // R7
    co_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_vld && main_vld) |-> sec_wid != main_wid);

    // R11
    sec_class_chk: assert property (@(posedge clk) disable iff (rst)
        sec_vld |-> (sec_op == 2'd1 || sec_op == 2'd3));

endmodule

// File: tb/warp_issue_sched_test.sv
`timescale 1ns/1ps
module warp_issue_sched_test;

    localparam int NW   = 32;
    localparam int WIDW = 5;
    localparam int RW   = 6;
    localparam int PCW  = 16;
    localparam int RPTW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NW-1:0]    vld;
    logic [1:0]       opa  [NW];
    logic [RW-1:0]    dsta [NW];
    logic [RW-1:0]    saa  [NW];
    logic [RW-1:0]    sba  [NW];
    logic [2*NW-1:0]  ins_op;
    logic [RW*NW-1:0] ins_dst, ins_sa, ins_sb;

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            ins_op[2*w +: 2]    = opa[w];
            ins_dst[RW*w +: RW] = dsta[w];
            ins_sa[RW*w +: RW]  = saa[w];
            ins_sb[RW*w +: RW]  = sba[w];
        end
    end

    logic            wb_vld = 1'b0;
    logic [WIDW-1:0] wb_wid = '0;
    logic [RW-1:0]   wb_reg = '0;
    logic            launch_req = 1'b0;
    logic [RPTW-1:0] launch_regs = '0;
    logic [PCW-1:0]  launch_pc = '0;
    logic            launch_ack;
    logic [WIDW-1:0] launch_wid;
    logic            retire_vld = 1'b0;
    logic [WIDW-1:0] retire_wid = '0;
    logic            main_vld, sec_vld;
    logic [WIDW-1:0] main_wid, sec_wid;
    logic [1:0]      main_op, sec_op;
    logic [PCW-1:0]  main_pc, sec_pc;

    warp_issue_sched uut (
        .clk(clk), .rst(rst), .ins_vld(vld), .ins_op(ins_op), .ins_dst(ins_dst),
        .ins_sa(ins_sa), .ins_sb(ins_sb), .wb_vld(wb_vld), .wb_wid(wb_wid), .wb_reg(wb_reg),
        .launch_req(launch_req), .launch_regs(launch_regs), .launch_pc(launch_pc),
        .launch_ack(launch_ack), .launch_wid(launch_wid), .retire_vld(retire_vld),
        .retire_wid(retire_wid), .main_vld(main_vld), .main_wid(main_wid), .main_op(main_op),
        .main_pc(main_pc), .sec_vld(sec_vld), .sec_wid(sec_wid), .sec_op(sec_op), .sec_pc(sec_pc)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic next();
        @(posedge clk); #1;
    endtask

    task automatic set_ins(input int w, input int op, input int d, input int a, input int b);
        vld[w] = 1'b1; opa[w] = 2'(op); dsta[w] = RW'(d); saa[w] = RW'(a); sba[w] = RW'(b);
    endtask

    task automatic quiet(input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (main_vld || sec_vld) bad++;
            next();
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic wait_issue(output bit mh, output int mw, output int mop, output int mpc,
                              output bit sh, output int sw, output int sop, output int spc,
                              output int at);
        bit got = 1'b0;
        mh = 0; sh = 0; mw = 0; mop = 0; mpc = 0; sw = 0; sop = 0; spc = 0; at = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            #1;
            if (main_vld || sec_vld) begin
                got = 1'b1;
                mh = main_vld; mw = int'(main_wid); mop = int'(main_op); mpc = int'(main_pc);
                sh = sec_vld;  sw = int'(sec_wid);  sop = int'(sec_op);  spc = int'(sec_pc);
                at = cyc;
            end
            next();
        end
        if (got) begin
            if (mh) vld[mw] = 1'b0;
            if (sh) vld[sw] = 1'b0;
        end else begin
            chk(1'b0, "issue timeout", 0, 1);
        end
    endtask

    task automatic launch(input int regs, input int pc, input bit exp_ack, input int exp_wid);
        launch_req = 1'b1; launch_regs = RPTW'(regs); launch_pc = PCW'(pc);
        #1;
        chk(launch_ack == exp_ack, "R8 launch accept", int'(launch_ack), int'(exp_ack));
        if (exp_ack) chk(int'(launch_wid) == exp_wid, "R8 lowest slot", int'(launch_wid), exp_wid);
        next();
        launch_req = 1'b0;
    endtask

    // completion then timed release of a blocked warp
    task automatic wb_release(input int w, input int r, input string tag);
        wb_vld = 1'b1; wb_wid = WIDW'(w); wb_reg = RW'(r);
        next();
        wb_vld = 1'b0;
        #1;
        chk(!main_vld && !sec_vld, {tag, " R4 early"}, int'(main_vld), 0);
        next();
        #1;
        chk(main_vld && int'(main_wid) == w, {tag, " R4 release"}, int'(main_wid), w);
        next();
        vld[w] = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk(!main_vld && !sec_vld, "R1 reset issue", int'(main_vld), 0);
        set_ins(0, 0, 3, 1, 2);
        quiet(5, "R1 no resident warp issues");
        vld[0] = 1'b0;
    endtask

    task automatic t_launch4();
        for (int w = 0; w < 4; w++) launch(16, 'h100 * (w + 1), 1'b1, w);
    endtask

    task automatic t_round_robin();
        bit mh, sh; int mw, mop, mpc, sw, sop, spc, at, prev;
        for (int w = 0; w < 4; w++) set_ins(w, 0, 8 + w, 1, 2);
        prev = 0;
        for (int w = 0; w < 4; w++) begin
            wait_issue(mh, mw, mop, mpc, sh, sw, sop, spc, at);
            chk(mh && mw == w, "R6 order", mw, w);
            chk(mpc == 'h100 * (w + 1), "R10 first pc", mpc, 'h100 * (w + 1));
            if (w > 0) chk(at - prev == 4, "R2 alu gap", at - prev, 4);
            prev = at;
        end
        set_ins(0, 0, 20, 1, 2);
        set_ins(2, 0, 20, 1, 2);
        wait_issue(mh, mw, mop, mpc, sh, sw, sop, spc, at);
        chk(mw == 0, "R6 wrap", mw, 0);
        chk(mpc == 'h101, "R10 pc step", mpc, 'h101);
        wait_issue(mh, mw, mop, mpc, sh, sw, sop, spc, at);
        chk(mw == 2, "R6 after wrap", mw, 2);
    endtask

    task automatic t_hazard();
        set_ins(1, 0, 21, 9, 2);
        set_ins(3, 0, 11, 1, 2);
        quiet(10, "R3 source and dest hazard");
        wb_release(1, 9, "R3 src");
        quiet(6, "R3 dest still pending");
        wb_release(3, 11, "R3 dst");
    endtask

    task automatic t_full();
        bit mh, sh; int mw, mop, mpc, sw, sop, spc, at;
        set_ins(0, 0, 22, 1, 2);
        wait_issue(mh, mw, mop, mpc, sh, sw, sop, spc, at);
        set_ins(0, 0, 23, 1, 2);
        wait_issue(mh, mw, mop, mpc, sh, sw, sop, spc, at);
        chk(mpc == 'h103, "R10 pc warp0", mpc, 'h103);
        set_ins(0, 0, 24, 1, 2);
        quiet(10, "R5 full scoreboard blocks");
        wb_release(0, 8, "R5");
    endtask

    task automatic t_coissue();
        bit mh, sh; int mw, mop, mpc, sw, sop, spc, at, t0;
        set_ins(1, 1, 30, 1, 2);
        set_ins(2, 0, 31, 1, 2);
        set_ins(3, 3, 32, 1, 2);
        wait_issue(mh, mw, mop, mpc, sh, sw, sop, spc, at);
        chk(mh && mw == 2 && mpc == 'h302, "R7 main of pair", mw, 2);
        chk(sh && sw == 1 && sop == 1, "R7 R11 mul co-issue", sw, 1);
        chk(spc == 'h202, "R10 sec pc", spc, 'h202);
        set_ins(2, 2, 33, 1, 2);
        t0 = at;
        wait_issue(mh, mw, mop, mpc, sh, sw, sop, spc, at);
        chk(at - t0 == 4, "R2 R7 next slot", at - t0, 4);
        chk(sh && sw == 3 && sop == 3 && spc == 'h402, "R7 R11 dp shares port", sw, 3);
        chk(mh && mw == 2 && mop == 2 && mpc == 'h303, "R11 imul on main", mop, 2);
        set_ins(1, 0, 34, 1, 2);
        t0 = at;
        wait_issue(mh, mw, mop, mpc, sh, sw, sop, spc, at);
        chk(mh && mw == 1 && at - t0 == 16, "R2 imul gap", at - t0, 16);
    endtask

    task automatic t_budget();
        launch(255, 'h500, 1'b1, 4);
        launch(200, 'h600, 1'b0, 0);
        retire_vld = 1'b1; retire_wid = 5'd4;
        launch_req = 1'b1; launch_regs = 8'd200; launch_pc = 16'h600;
        #1;
        chk(!launch_ack, "R9 same cycle retire uses old budget", int'(launch_ack), 0);
        next();
        retire_vld = 1'b0;
        launch_req = 1'b0;
        launch(200, 'h600, 1'b1, 4);
    endtask

    initial begin
        vld = '0;
        for (int w = 0; w < NW; w++) begin
            opa[w] = '0; dsta[w] = '0; saa[w] = '0; sba[w] = '0;
        end
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_launch4();
        t_round_robin();
        t_hazard();
        t_full();
        t_coissue();
        t_budget();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule